// File: doc/BRIEF.md
# Converter Calibration Mode Sequencer

This block steers the operating mode of a two-channel sigma-delta converter. A host writes a 2-bit mode field together with a channel select. Mode 00 lets ordinary conversions run, and each conversion-done strobe from the modulator core loads the measured word into the data output. The other three codes start a calibration on the selected channel:

- A self-calibration measures an internal zero-scale and then an internal full-scale level.
- A system zero-scale calibration measures the offset at the channel input.
- A system full-scale calibration measures the full-scale level at the channel input.

Each calibration phase lets a parameterised number of conversion strobes go by so the filter can settle. The measurement on the last of those strobes is stored in the offset register or the gain register of the calibrated channel. When the calibration is done, the mode field returns to normal without any host write.

The not-ready flag `drdy` rises as soon as a calibration is accepted. It falls in the same cycle that the mode field returns to normal and the final measured word appears on the data output. The analog input routing is only modelled: it appears as a select code for the front end. A change to the digital filter setting marks the stored calibration as stale, and the next completed calibration clears that mark.

Top module: `cal_seq`

## Requirements
- R1: After reset, `mode_o`=00, `drdy`=0, `data_o`=0, every offset register is 0, every gain register equals GAIN_RST (default 0x8000), `in_sel`=00 and `recal_o`=1.
- R2: In mode 00, each `conv_done` loads `meas` into `data_o` in the following cycle, `drdy` stays 0, no offset or gain register changes, and `in_sel` is 00 (channel input).
- R3: A `mode_wr` with a nonzero `mode_in` in mode 00 sets `mode_o` to `mode_in`, latches `chan_in` into `chan_o` and raises `drdy` in the next cycle. A `mode_wr` with `mode_in`=00 only latches the channel.
- R4: Mode 01 first runs a zero-scale phase with `in_sel`=01 (inputs shorted). On its SETTLE-th `conv_done` it stores `meas` in the selected channel's offset register. It then runs a full-scale phase with `in_sel`=10 (reference divided by gain), and on that phase's SETTLE-th `conv_done` it stores `meas` in the channel's gain register.
- R5: Mode 10 runs one phase with `in_sel`=00. It stores the SETTLE-th measurement in the selected offset register and leaves every gain register unchanged.
- R6: Mode 11 runs one phase with `in_sel`=00. It stores the SETTLE-th measurement in the selected gain register and leaves every offset register unchanged.
- R7: In the cycle after the final capturing strobe, `mode_o` reads 00, `drdy` reads 0 and `data_o` holds the captured measurement.
- R8: The offset and gain registers of a channel that is not being calibrated never change.
- R9: A `mode_wr` that arrives while a calibration is running is ignored: `mode_o`, `chan_o` and the calibration flow are unchanged.
- R10: `filt_chg` sets `recal_o` in the next cycle. Completing any calibration clears it, and if both happen in the same cycle, `filt_chg` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Host write strobe for mode and channel |
| mode_in | input | 2 | Requested mode code |
| chan_in | input | CHW | Requested channel |
| filt_chg | input | 1 | Filter setting changed |
| conv_done | input | 1 | Conversion-done strobe from the core |
| meas | input | DW | Measured word from the core |
| mode_o | output | 2 | Current mode field |
| chan_o | output | CHW | Latched channel |
| drdy | output | 1 | High while a calibration is running |
| data_o | output | DW | Data word register |
| in_sel | output | 2 | Front-end input routing select |
| recal_o | output | 1 | Calibration is stale |
| off_o | output | NUM_CH*DW | Offset registers, channel 0 in the low bits |
| gain_o | output | NUM_CH*DW | Gain registers, channel 0 in the low bits |

## Verification
The hardest situations to reach are the phase boundaries of a self-calibration. These are the cycle where a zero-scale capture hands over to the full-scale phase, and the final strobe that coincides with a host mode write or a filter change. Random stimulus alone rarely hits them. Directed sequences therefore count strobes exactly, place writes and filter changes on the capturing cycle, and alternate channels so that a disturbance of the idle channel would show up. A long random run with frequent strobes and occasional mode writes is then compared cycle by cycle against a bench model.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;
    typedef enum logic [1:0] {
        MODE_NORMAL   = 2'b00,
        MODE_SELF     = 2'b01,
        MODE_SYS_ZERO = 2'b10,
        MODE_SYS_FULL = 2'b11
    } cal_mode_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_ZERO = 2'b01,
        PH_FULL = 2'b10
    } cal_phase_e;

    localparam logic [1:0] SEL_INPUT = 2'b00;
    localparam logic [1:0] SEL_SHORT = 2'b01;
    localparam logic [1:0] SEL_REF   = 2'b10;
endpackage

// File: rtl/cal_seq_strobe_ctr.sv
module cal_seq_strobe_ctr #(
    parameter int SETTLE = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic hit
);
    localparam int CW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
    localparam logic [CW-1:0] LAST = CW'(SETTLE - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign hit = tick && (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (clear || hit) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/cal_seq_corr_bank.sv
module cal_seq_corr_bank #(
    parameter int          NUM_CH = 2,
    parameter int          DW     = 16,
    parameter logic [DW-1:0] RST_VAL = '0,
    localparam int         CHW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [CHW-1:0]       wr_ch,
    input  logic [DW-1:0]        wr_data,
    output logic [NUM_CH*DW-1:0] regs_o
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic [DW-1:0] val_d, val_q;

        always_comb begin
            val_d = val_q;
            if (wr_en && (wr_ch == CHW'(i))) val_d = wr_data;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) val_q <= RST_VAL;
            else        val_q <= val_d;
        end

        assign regs_o[i*DW +: DW] = val_q;
    end
endmodule

// File: rtl/cal_seq.sv
module cal_seq
    import cal_seq_pkg::*;
#(
    parameter int            NUM_CH   = 2,
    parameter int            DW       = 16,
    parameter int            SETTLE   = 3,
    parameter logic [DW-1:0] GAIN_RST = 16'h8000,
    localparam int           CHW      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode_wr,
    input  logic [1:0]           mode_in,
    input  logic [CHW-1:0]       chan_in,
    input  logic                 filt_chg,
    input  logic                 conv_done,
    input  logic [DW-1:0]        meas,
    output logic [1:0]           mode_o,
    output logic [CHW-1:0]       chan_o,
    output logic                 drdy,
    output logic [DW-1:0]        data_o,
    output logic [1:0]           in_sel,
    output logic                 recal_o,
    output logic [NUM_CH*DW-1:0] off_o,
    output logic [NUM_CH*DW-1:0] gain_o
);
    typedef struct packed {
        cal_phase_e     ph;
        cal_mode_e      mode;
        logic [CHW-1:0] ch;
        logic           drdy;
        logic [DW-1:0]  data;
        logic           stale;
    } seq_t;

    seq_t s_d, s_q;
    logic off_we, gain_we, hit;

    cal_seq_strobe_ctr #(.SETTLE(SETTLE)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (s_q.ph == PH_IDLE),
        .tick  (conv_done && (s_q.ph != PH_IDLE)),
        .hit   (hit)
    );

    cal_seq_corr_bank #(.NUM_CH(NUM_CH), .DW(DW), .RST_VAL('0)) u_off (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (off_we),
        .wr_ch   (s_q.ch),
        .wr_data (meas),
        .regs_o  (off_o)
    );

    cal_seq_corr_bank #(.NUM_CH(NUM_CH), .DW(DW), .RST_VAL(GAIN_RST)) u_gain (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (gain_we),
        .wr_ch   (s_q.ch),
        .wr_data (meas),
        .regs_o  (gain_o)
    );

    always_comb begin
        logic finish;
        s_d     = s_q;
        off_we  = 1'b0;
        gain_we = 1'b0;
        finish  = 1'b0;
        case (s_q.ph)
            PH_IDLE: begin
                if (conv_done) s_d.data = meas;
                if (mode_wr) begin
                    s_d.ch = chan_in;
                    if (cal_mode_e'(mode_in) != MODE_NORMAL) begin
                        s_d.mode = cal_mode_e'(mode_in);
                        s_d.drdy = 1'b1;
                        s_d.ph   = (cal_mode_e'(mode_in) == MODE_SYS_FULL) ? PH_FULL : PH_ZERO;
                    end
                end
            end
            PH_ZERO: begin
                if (hit) begin
                    off_we = 1'b1;
                    if (s_q.mode == MODE_SELF) s_d.ph = PH_FULL;
                    else                       finish = 1'b1;
                end
            end
            PH_FULL: begin
                if (hit) begin
                    gain_we = 1'b1;
                    finish  = 1'b1;
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
        if (finish) begin
            s_d.ph    = PH_IDLE;
            s_d.mode  = MODE_NORMAL;
            s_d.drdy  = 1'b0;
            s_d.data  = meas;
            s_d.stale = 1'b0;
        end
        if (filt_chg) s_d.stale = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_IDLE, mode: MODE_NORMAL, ch: '0, drdy: 1'b0,
                     data: '0, stale: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        in_sel = SEL_INPUT;
        if (s_q.mode == MODE_SELF) begin
            if (s_q.ph == PH_ZERO)      in_sel = SEL_SHORT;
            else if (s_q.ph == PH_FULL) in_sel = SEL_REF;
        end
    end

    assign mode_o  = s_q.mode;
    assign chan_o  = s_q.ch;
    assign drdy    = s_q.drdy;
    assign data_o  = s_q.data;
    assign recal_o = s_q.stale;
endmodule

// File: rtl/cal_seq_chk.sv
module cal_seq_chk #(
    parameter int NUM_CH = 2,
    parameter int DW     = 16,
    localparam int CHW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 mode_wr,
    input logic                 conv_done,
    input logic                 filt_chg,
    input logic [1:0]           mode_o,
    input logic [CHW-1:0]       chan_o,
    input logic                 drdy,
    input logic [1:0]           in_sel,
    input logic                 recal_o,
    input logic [NUM_CH*DW-1:0] off_o,
    input logic [NUM_CH*DW-1:0] gain_o
);
    AST_NORMAL_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b00) |-> (in_sel == 2'b00 && !drdy));                   // R2
    AST_NORMAL_REGS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b00) |=> ($stable(off_o) && $stable(gain_o)));          // R2
    AST_CAL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != 2'b00) |-> drdy);                                         // R3
    AST_ZERO_KEEPS_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b10) |=> $stable(gain_o));                              // R5
    AST_FULL_KEEPS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b11) |=> $stable(off_o));                               // R6
    AST_DONE_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drdy) |-> (mode_o == 2'b00));                                  // R7
    AST_CAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != 2'b00 && !conv_done) |=> ($stable(mode_o) && $stable(chan_o))); // R9
    AST_CAL_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != 2'b00 && mode_wr) |=> $stable(chan_o));                   // R9
    AST_STALE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        filt_chg |=> recal_o);                                               // R10

    for (genvar i = 0; i < NUM_CH; i++) begin : g_other
        AST_OTHER_CH: assert property (@(posedge clk) disable iff (!rst_n)
            (chan_o != CHW'(i)) |=> ($stable(off_o[i*DW +: DW]) && $stable(gain_o[i*DW +: DW]))); // R8
    end
endmodule

bind cal_seq cal_seq_chk #(.NUM_CH(NUM_CH), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_wr   (mode_wr),
    .conv_done (conv_done),
    .filt_chg  (filt_chg),
    .mode_o    (mode_o),
    .chan_o    (chan_o),
    .drdy      (drdy),
    .in_sel    (in_sel),
    .recal_o   (recal_o),
    .off_o     (off_o),
    .gain_o    (gain_o)
);

// File: tb/cal_seq_tb.sv
`timescale 1ns/1ps
module cal_seq_tb;
    localparam int SETTLE = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_wr = 1'b0;
    logic [1:0]  mode_in = 2'b00;
    logic        chan_in = 1'b0;
    logic        filt_chg = 1'b0;
    logic        conv_done = 1'b0;
    logic [15:0] meas = '0;
    logic [1:0]  mode_o;
    logic        chan_o;
    logic        drdy;
    logic [15:0] data_o;
    logic [1:0]  in_sel;
    logic        recal_o;
    logic [31:0] off_o, gain_o;

    int vectors = 0;
    int fails   = 0;

    // bench model state
    int          m_ph = 0;          // 0 idle, 1 zero phase, 2 full phase
    int          m_cnt = 0;
    logic [1:0]  m_mode = 2'b00;
    logic        m_ch = 1'b0;
    logic        m_drdy = 1'b0;
    logic [15:0] m_data = '0;
    logic        m_stale = 1'b1;
    logic [15:0] m_off [2] = '{16'h0, 16'h0};
    logic [15:0] m_gain [2] = '{16'h8000, 16'h8000};

    always #2 clk = ~clk;

    cal_seq u_dut (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_in(mode_in),
        .chan_in(chan_in), .filt_chg(filt_chg), .conv_done(conv_done),
        .meas(meas), .mode_o(mode_o), .chan_o(chan_o), .drdy(drdy),
        .data_o(data_o), .in_sel(in_sel), .recal_o(recal_o),
        .off_o(off_o), .gain_o(gain_o)
    );

    function automatic logic [1:0] exp_sel(int ph, logic [1:0] md);
        if (md == 2'b01 && ph == 1) return 2'b01;
        if (md == 2'b01 && ph == 2) return 2'b10;
        return 2'b00;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model_step();
        bit fin = 0;
        if (m_ph == 0) begin
            if (conv_done) m_data = meas;
            if (mode_wr) begin
                m_ch = chan_in;
                if (mode_in != 2'b00) begin
                    m_mode = mode_in;
                    m_drdy = 1'b1;
                    m_ph   = (mode_in == 2'b11) ? 2 : 1;
                    m_cnt  = 0;
                end
            end
        end else if (conv_done) begin
            if (m_cnt == SETTLE - 1) begin
                m_cnt = 0;
                if (m_ph == 1) begin
                    m_off[m_ch] = meas;
                    if (m_mode == 2'b01) m_ph = 2;
                    else fin = 1;
                end else begin
                    m_gain[m_ch] = meas;
                    fin = 1;
                end
            end else begin
                m_cnt++;
            end
        end
        if (fin) begin
            m_ph = 0; m_mode = 2'b00; m_drdy = 1'b0; m_data = meas; m_stale = 1'b0;
        end
        if (filt_chg) m_stale = 1'b1;
    endtask

    task automatic compare_all();
        check(mode_o == m_mode, "R9", "mode", 32'(mode_o), 32'(m_mode));
        check(chan_o == m_ch, "R3", "chan", 32'(chan_o), 32'(m_ch));
        check(drdy == m_drdy, "R3", "drdy", 32'(drdy), 32'(m_drdy));
        check(data_o == m_data, "R7", "data", 32'(data_o), 32'(m_data));
        check(in_sel == exp_sel(m_ph, m_mode), "R4", "in_sel", 32'(in_sel),
              32'(exp_sel(m_ph, m_mode)));
        check(recal_o == m_stale, "R10", "recal", 32'(recal_o), 32'(m_stale));
        check(off_o == {m_off[1], m_off[0]}, "R5", "offsets", off_o, {m_off[1], m_off[0]});
        check(gain_o == {m_gain[1], m_gain[0]}, "R6", "gains", gain_o, {m_gain[1], m_gain[0]});
    endtask

    // apply one cycle of inputs, then compare at the following falling edge
    task automatic step(input bit wr, input logic [1:0] md, input logic ch,
                        input bit cd, input logic [15:0] mv, input bit fc);
        mode_wr = wr; mode_in = md; chan_in = ch;
        conv_done = cd; meas = mv; filt_chg = fc;
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 2'b00, 0, 0, 16'h0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog: actual timeout expected completion");
        fails++;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd7705));
        repeat (3) @(negedge clk);
        // R1: reset values
        check(mode_o == 2'b00 && drdy == 1'b0 && data_o == 16'h0, "R1", "mode/drdy/data",
              {13'h0, mode_o, drdy, data_o}, 32'h0);
        check(off_o == 32'h0 && gain_o == 32'h8000_8000, "R1", "corr regs", gain_o, 32'h8000_8000);
        check(in_sel == 2'b00 && recal_o == 1'b1, "R1", "sel/recal", {in_sel, recal_o}, 3'b001);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: normal conversions load the data word only
        step(0, 2'b00, 0, 1, 16'h1234, 0);
        check(data_o == 16'h1234 && drdy == 1'b0, "R2", "normal data", data_o, 16'h1234);
        step(0, 2'b00, 0, 1, 16'hBEEF, 0);
        check(off_o == 32'h0 && gain_o == 32'h8000_8000, "R2", "regs unchanged", off_o, 32'h0);

        // R3, R4, R7, R8: self-calibration of channel 1
        step(1, 2'b01, 1, 0, 16'h0, 0);
        check(mode_o == 2'b01 && drdy && chan_o == 1'b1, "R3", "cal start",
              {mode_o, drdy, chan_o}, 4'b0111);
        check(in_sel == 2'b01, "R4", "short select", 32'(in_sel), 32'h1);
        step(0, 2'b00, 0, 1, 16'h0011, 0);
        step(1, 2'b10, 0, 0, 16'h0, 0);                 // R9: ignored write
        check(mode_o == 2'b01 && chan_o == 1'b1, "R9", "write ignored", {mode_o, chan_o}, 3'b011);
        step(0, 2'b00, 0, 1, 16'h0022, 0);
        step(0, 2'b00, 0, 1, 16'h0033, 0);
        check(off_o == 32'h0033_0000 && in_sel == 2'b10, "R4", "offset ch1 + ref select",
              off_o, 32'h0033_0000);
        step(0, 2'b00, 0, 1, 16'h0044, 0);
        step(0, 2'b00, 0, 1, 16'h0055, 0);
        step(1, 2'b11, 0, 1, 16'h0066, 1);              // final strobe with write and filter change
        check(gain_o == 32'h0066_8000, "R4", "gain ch1", gain_o, 32'h0066_8000);
        check(mode_o == 2'b00 && !drdy && data_o == 16'h0066, "R7", "completion",
              {mode_o, drdy, data_o}, 32'h0066);
        check(off_o[15:0] == 16'h0 && gain_o[15:0] == 16'h8000, "R8", "ch0 untouched",
              {off_o[15:0], gain_o[15:0]}, 32'h0000_8000);
        check(recal_o == 1'b1, "R10", "filter change wins", 32'(recal_o), 32'h1);

        // R5: zero-scale system calibration of channel 0
        step(1, 2'b10, 0, 0, 16'h0, 0);
        for (int i = 0; i < SETTLE; i++) step(0, 2'b00, 0, 1, 16'h0100 + 16'(i), 0);
        check(off_o == 32'h0033_0102 && gain_o == 32'h0066_8000, "R5", "offset only",
              off_o, 32'h0033_0102);
        check(recal_o == 1'b0, "R10", "cleared by cal", 32'(recal_o), 32'h0);

        // R6: full-scale system calibration of channel 0
        step(1, 2'b11, 0, 0, 16'h0, 0);
        check(in_sel == 2'b00, "R6", "input select", 32'(in_sel), 32'h0);
        for (int i = 0; i < SETTLE; i++) step(0, 2'b00, 0, 1, 16'h0A00 + 16'(i), 0);
        check(gain_o == 32'h0066_0A02 && off_o == 32'h0033_0102, "R6", "gain only",
              gain_o, 32'h0066_0A02);
        check(off_o[31:16] == 16'h0033 && gain_o[31:16] == 16'h0066, "R8", "ch1 untouched",
              {off_o[31:16], gain_o[31:16]}, 32'h0033_0066);
        idle(2);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            step(($urandom % 8) == 0, 2'($urandom), 1'($urandom),
                 ($urandom % 2) == 0, 16'($urandom), ($urandom % 50) == 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule